// File: doc/BRIEF.md
# Blocking Memory Step Sequencer

This block is the control sequencer of a small in-order core that never has more than one memory transaction in flight. From the Running state it sends an instruction fetch on the instruction port. When the fetch response comes back, the instruction is handled in one of two ways. An ordinary instruction, or a data prefetch, retires at once. A load or store instead issues a single request on the data port and retires when that request's response arrives. Both ports use the same scheme. A request is offered for one cycle and the accept input is sampled in that same cycle. A request that is turned down is kept and offered again only when the port pulses its retry input. A response is a one-cycle strobe, taken at the clock edge that samples it. Any response time therefore resolves to the next whole clock period.

Decode, execute, address translation and the memories stay outside the block. They appear only as a few sampled inputs: a memory-operation flag, a prefetch flag, a fetch fault and a data-access fault. The block drives a retire strobe and the program counter. Around this core loop it handles several controls:
- activate, with a start delay;
- suspend;
- a switched-out mode;
- a drain handshake;
- interrupt redirection before each fetch;
- a cycle counter;
- a sticky protocol-error flag.

Top module: `mem_step_sequencer`

## Requirements
- R1: After reset, state_o is Idle (code 0), pc_o equals RESET_PC (0), no request is driven, cycles_o is 0 and error_o is 0.
- R2: activate_i sampled in Idle sets state Running (code 1) and loads the start delay D from act_delay_i. Counting from the edge that samples activate_i, if_req_o first rises D clock cycles later, so D = 0 means the very next cycle.
- R3: A fetch offered with if_accept_i high moves to IcacheWait (code 3). Offered with if_accept_i low, it moves to IcacheRetry (code 2). In IcacheRetry the block keeps if_addr_o and offers no request until if_retry_i pulses. On that pulse it offers the request again and leaves for IcacheWait only if the request is then accepted.
- R4: A fetch response whose instruction is not a memory operation, or is a prefetch (is_prefetch_i = 1), pulses inst_done_o in the response cycle. The response adds INST_BYTES (4) to pc_o and returns the state to Running.
- R5: A fetch response for a memory operation that is not a prefetch drives dm_req_o in that same cycle. The data port follows the R3 scheme, with DcacheRetry as code 4 and DcacheWait as code 5. The data response pulses inst_done_o, adds 4 to the PC and returns to Running.
- R6: If acc_fault_i is high with a memory-operation fetch response, no data request is sent. inst_done_o pulses, pc_o becomes FAULT_VEC (0x100) and the state is Running.
- R7: If fetch_fault_i is high when a fetch would be launched, no fetch request is sent and pc_o becomes FAULT_VEC. The state stays Running and the next fetch follows in the next cycle.
- R8: Interrupts are checked before each fetch. If intr_i is high when a fetch would be launched, no request is sent, intr_ack_o pulses and pc_o becomes INTR_VEC (0x200). This takes priority over fetch_fault_i.
- R9: While drain_req_i is high in Idle, Running or SwitchedOut, drained_o is high and no fetch starts. A drain request raised in any wait or retry state is remembered. The next response of that transaction then returns the state to Running without retiring the instruction and without changing pc_o. Once drain_req_i falls, fetching resumes at the unchanged PC.
- R10: suspend_i in Running moves to Idle with no fetch. A suspend seen in a wait or retry state lets the current instruction finish, after which the block goes to Idle. No fetch is issued in Idle.
- R11: switch_out_i in Idle or Running moves to SwitchedOut (code 6). activate_i leaves SwitchedOut for Running.
- R12: cycles_o increments by one on every clock edge at which the state is not SwitchedOut, and holds while the state is SwitchedOut.
- R13: error_o sets and stays set in any of these cases:
  - a retry pulse arrives on a port that is not in its retry state;
  - a response arrives on a port that is not in its wait state;
  - activate_i is seen outside Idle or SwitchedOut;
  - switch_out_i is seen outside Idle or Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Start the thread (from Idle or SwitchedOut) |
| act_delay_i | input | DLY_W | Cycles to wait before the first fetch |
| suspend_i | input | 1 | Park the thread in Idle |
| switch_out_i | input | 1 | Enter SwitchedOut |
| drain_req_i | input | 1 | Drain request (level) |
| drained_o | output | 1 | Drain acknowledged, block quiescent |
| intr_i | input | 1 | Interrupt pending |
| intr_ack_o | output | 1 | Interrupt taken, PC redirected |
| fetch_fault_i | input | 1 | Translation fault for the current fetch |
| if_req_o | output | 1 | Instruction request offered |
| if_addr_o | output | AW | Instruction request address |
| if_accept_i | input | 1 | Instruction request accepted this cycle |
| if_retry_i | input | 1 | Instruction port retry pulse |
| if_resp_i | input | 1 | Instruction response strobe |
| is_mem_i | input | 1 | Fetched instruction is a load or store |
| is_prefetch_i | input | 1 | Fetched memory instruction is a data prefetch |
| acc_fault_i | input | 1 | Fault while starting the data access |
| dm_req_o | output | 1 | Data request offered |
| dm_accept_i | input | 1 | Data request accepted this cycle |
| dm_retry_i | input | 1 | Data port retry pulse |
| dm_resp_i | input | 1 | Data response strobe |
| inst_done_o | output | 1 | Instruction retired this cycle |
| pc_o | output | AW | Program counter |
| state_o | output | 3 | Controller state code |
| cycles_o | output | CW | Cycle counter |
| error_o | output | 1 | Sticky protocol error |

## Verification
The outputs if_req_o, dm_req_o, inst_done_o, intr_ack_o and drained_o are combinational. They are due in the same cycle as the input that causes them, so the bench drives inputs after a falling edge and checks these outputs one time unit later. pc_o, state_o, cycles_o and error_o are registered and change one edge after the sampled event. The start delay is the exception: the first fetch is due exactly D edges after the edge that samples activate_i. The bench checks for a missing request at each of those cycles and for its presence at the last one. Every registered check is made at the falling edge that follows the stepping edge.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN      = 3'd1,
    ST_IF_RETRY = 3'd2,
    ST_IF_WAIT  = 3'd3,
    ST_DM_RETRY = 3'd4,
    ST_DM_WAIT  = 3'd5,
    ST_SWOUT    = 3'd6
  } mss_state_e;
endpackage

// File: rtl/mss_delay.sv
module mss_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_n  = val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mss_cycles.sv
module mss_cycles #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb cnt_n = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mss_err.sv
module mss_err
  import mss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mss_state_e st_i,
  input  logic [1:0] retry_i,
  input  logic [1:0] resp_i,
  input  logic       activate_i,
  input  logic       switch_out_i,
  output logic       error_o
);
  logic [1:0] port_bad;
  logic       ctl_bad, err_q, err_n;

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam mss_state_e RETRY_ST = (p == 0) ? ST_IF_RETRY : ST_DM_RETRY;
    localparam mss_state_e WAIT_ST  = (p == 0) ? ST_IF_WAIT  : ST_DM_WAIT;
    assign port_bad[p] = (retry_i[p] && (st_i != RETRY_ST)) ||
                         (resp_i[p]  && (st_i != WAIT_ST));
  end

  assign ctl_bad = (activate_i && !(st_i == ST_IDLE || st_i == ST_SWOUT)) ||
                   (switch_out_i && !(st_i == ST_IDLE || st_i == ST_RUN));

  always_comb err_n = err_q | (|port_bad) | ctl_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  assign error_o = err_q;
endmodule

// File: rtl/mss_fsm.sv
module mss_fsm
  import mss_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC  = '0,
  parameter logic [AW-1:0] FAULT_VEC = 'h100,
  parameter logic [AW-1:0] INTR_VEC  = 'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          activate_i,
  input  logic          suspend_i,
  input  logic          switch_out_i,
  input  logic          drain_req_i,
  input  logic          intr_i,
  input  logic          fetch_fault_i,
  input  logic          if_accept_i,
  input  logic          if_retry_i,
  input  logic          if_resp_i,
  input  logic          is_mem_i,
  input  logic          is_prefetch_i,
  input  logic          acc_fault_i,
  input  logic          dm_accept_i,
  input  logic          dm_retry_i,
  input  logic          dm_resp_i,
  input  logic          dly_zero_i,
  output mss_state_e    st_o,
  output logic [AW-1:0] pc_o,
  output logic          if_req_o,
  output logic          dm_req_o,
  output logic          intr_ack_o,
  output logic          inst_done_o,
  output logic          dly_load_o
);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  mss_state_e    st_q, st_n, after_st;
  logic [AW-1:0] pc_q, pc_n;
  logic          susp_q, susp_n, drn_q, drn_n;
  logic          busy, draining;

  assign busy     = (st_q == ST_IF_RETRY) || (st_q == ST_IF_WAIT) ||
                    (st_q == ST_DM_RETRY) || (st_q == ST_DM_WAIT);
  assign draining = drn_q || drain_req_i;
  assign after_st = (susp_q || suspend_i) ? ST_IDLE : ST_RUN;

  always_comb begin
    st_n        = st_q;
    pc_n        = pc_q;
    susp_n      = susp_q;
    drn_n       = drn_q;
    if_req_o    = 1'b0;
    dm_req_o    = 1'b0;
    intr_ack_o  = 1'b0;
    inst_done_o = 1'b0;
    dly_load_o  = 1'b0;
    if (busy) begin
      if (suspend_i)   susp_n = 1'b1;
      if (drain_req_i) drn_n  = 1'b1;
    end
    case (st_q)
      ST_IDLE: begin
        if (activate_i) begin
          st_n       = ST_RUN;
          dly_load_o = 1'b1;
        end else if (switch_out_i) begin
          st_n = ST_SWOUT;
        end
      end
      ST_SWOUT: begin
        if (activate_i) begin
          st_n       = ST_RUN;
          dly_load_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (switch_out_i) begin
          st_n = ST_SWOUT;
        end else if (suspend_i) begin
          st_n = ST_IDLE;
        end else if (dly_zero_i && !drain_req_i) begin
          if (intr_i) begin
            intr_ack_o = 1'b1;
            pc_n       = INTR_VEC;
          end else if (fetch_fault_i) begin
            pc_n = FAULT_VEC;
          end else begin
            if_req_o = 1'b1;
            st_n     = if_accept_i ? ST_IF_WAIT : ST_IF_RETRY;
          end
        end
      end
      ST_IF_RETRY: begin
        if (if_retry_i) begin
          if_req_o = 1'b1;
          if (if_accept_i) st_n = ST_IF_WAIT;
        end
      end
      ST_IF_WAIT: begin
        if (if_resp_i) begin
          if (draining) begin
            st_n = after_st;
          end else if (is_mem_i && !is_prefetch_i) begin
            if (acc_fault_i) begin
              pc_n        = FAULT_VEC;
              inst_done_o = 1'b1;
              st_n        = after_st;
            end else begin
              dm_req_o = 1'b1;
              st_n     = dm_accept_i ? ST_DM_WAIT : ST_DM_RETRY;
            end
          end else begin
            pc_n        = pc_q + STEP;
            inst_done_o = 1'b1;
            st_n        = after_st;
          end
        end
      end
      ST_DM_RETRY: begin
        if (dm_retry_i) begin
          dm_req_o = 1'b1;
          if (dm_accept_i) st_n = ST_DM_WAIT;
        end
      end
      ST_DM_WAIT: begin
        if (dm_resp_i) begin
          st_n = after_st;
          if (!draining) begin
            pc_n        = pc_q + STEP;
            inst_done_o = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (!((st_n == ST_IF_RETRY) || (st_n == ST_IF_WAIT) ||
          (st_n == ST_DM_RETRY) || (st_n == ST_DM_WAIT))) begin
      susp_n = 1'b0;
      drn_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= RESET_PC;
      susp_q <= 1'b0;
      drn_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pc_q   <= pc_n;
      susp_q <= susp_n;
      drn_q  <= drn_n;
    end
  end

  assign st_o = st_q;
  assign pc_o = pc_q;
endmodule

// File: rtl/mem_step_sequencer.sv
module mem_step_sequencer
  import mss_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DLY_W      = 8,
  parameter int          CW         = 32,
  parameter int          INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC  = '0,
  parameter logic [AW-1:0] FAULT_VEC = 'h100,
  parameter logic [AW-1:0] INTR_VEC  = 'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             switch_out_i,
  input  logic             drain_req_i,
  output logic             drained_o,
  input  logic             intr_i,
  output logic             intr_ack_o,
  input  logic             fetch_fault_i,
  output logic             if_req_o,
  output logic [AW-1:0]    if_addr_o,
  input  logic             if_accept_i,
  input  logic             if_retry_i,
  input  logic             if_resp_i,
  input  logic             is_mem_i,
  input  logic             is_prefetch_i,
  input  logic             acc_fault_i,
  output logic             dm_req_o,
  input  logic             dm_accept_i,
  input  logic             dm_retry_i,
  input  logic             dm_resp_i,
  output logic             inst_done_o,
  output logic [AW-1:0]    pc_o,
  output logic [2:0]       state_o,
  output logic [CW-1:0]    cycles_o,
  output logic             error_o
);
  mss_state_e st;
  logic       dly_zero, dly_load;

  mss_fsm #(
    .AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC),
    .FAULT_VEC(FAULT_VEC), .INTR_VEC(INTR_VEC)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .activate_i(activate_i), .suspend_i(suspend_i),
    .switch_out_i(switch_out_i), .drain_req_i(drain_req_i),
    .intr_i(intr_i), .fetch_fault_i(fetch_fault_i),
    .if_accept_i(if_accept_i), .if_retry_i(if_retry_i), .if_resp_i(if_resp_i),
    .is_mem_i(is_mem_i), .is_prefetch_i(is_prefetch_i), .acc_fault_i(acc_fault_i),
    .dm_accept_i(dm_accept_i), .dm_retry_i(dm_retry_i), .dm_resp_i(dm_resp_i),
    .dly_zero_i(dly_zero),
    .st_o(st), .pc_o(pc_o), .if_req_o(if_req_o), .dm_req_o(dm_req_o),
    .intr_ack_o(intr_ack_o), .inst_done_o(inst_done_o), .dly_load_o(dly_load)
  );

  mss_delay #(.DLY_W(DLY_W)) i_delay (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .val_i(act_delay_i),
    .run_i(st == ST_RUN), .zero_o(dly_zero)
  );

  mss_cycles #(.CW(CW)) i_cycles (
    .clk(clk), .rst_n(rst_n), .en_i(st != ST_SWOUT), .cnt_o(cycles_o)
  );

  mss_err i_err (
    .clk(clk), .rst_n(rst_n), .st_i(st),
    .retry_i({dm_retry_i, if_retry_i}), .resp_i({dm_resp_i, if_resp_i}),
    .activate_i(activate_i), .switch_out_i(switch_out_i), .error_o(error_o)
  );

  assign if_addr_o = pc_o;
  assign state_o   = st;
  assign drained_o = drain_req_i &&
                     ((st == ST_IDLE) || (st == ST_RUN) || (st == ST_SWOUT));
endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    state_o,
  input logic          if_req_o,
  input logic          if_accept_i,
  input logic          if_retry_i,
  input logic          dm_req_o,
  input logic          dm_accept_i,
  input logic          drained_o,
  input logic [CW-1:0] cycles_o,
  input logic          error_o
);
  AST_IF_ACCEPT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_o && if_accept_i) |=> (state_o == 3'd3)); // R3
  AST_IF_REJECT_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_o && !if_accept_i) |=> (state_o == 3'd2)); // R3
  AST_RETRY_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd2) && !if_retry_i) |-> !if_req_o); // R3
  AST_DM_ACCEPT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req_o && dm_accept_i) |=> (state_o == 3'd5)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_req_o && dm_req_o)); // R5
  AST_DRAINED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drained_o |-> (!if_req_o && !dm_req_o)); // R9
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> !if_req_o); // R10
  AST_CYCLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |=> $stable(cycles_o)); // R12
  AST_CYCLES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'd6) |=> (cycles_o == $past(cycles_o) + 1'b1)); // R12
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o); // R13
endmodule

bind mem_step_sequencer mss_checker #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .if_req_o(if_req_o),
  .if_accept_i(if_accept_i), .if_retry_i(if_retry_i), .dm_req_o(dm_req_o),
  .dm_accept_i(dm_accept_i), .drained_o(drained_o), .cycles_o(cycles_o),
  .error_o(error_o)
);

// File: tb/test_mem_step_sequencer.sv
`timescale 1ns/1ps
module test_mem_step_sequencer;
  logic        clk, rst_n;
  logic        activate_i, suspend_i, switch_out_i, drain_req_i, intr_i, fetch_fault_i;
  logic [7:0]  act_delay_i;
  logic        if_accept_i, if_retry_i, if_resp_i, is_mem_i, is_prefetch_i, acc_fault_i;
  logic        dm_accept_i, dm_retry_i, dm_resp_i;
  logic        drained_o, intr_ack_o, if_req_o, dm_req_o, inst_done_o, error_o;
  logic [31:0] if_addr_o, pc_o, cycles_o;
  logic [2:0]  state_o;

  int tests, fails;
  logic [31:0] exp_pc, c0;
  bit finished;

  mem_step_sequencer i_mem_step_sequencer (
    .clk(clk), .rst_n(rst_n), .activate_i(activate_i), .act_delay_i(act_delay_i),
    .suspend_i(suspend_i), .switch_out_i(switch_out_i), .drain_req_i(drain_req_i),
    .drained_o(drained_o), .intr_i(intr_i), .intr_ack_o(intr_ack_o),
    .fetch_fault_i(fetch_fault_i), .if_req_o(if_req_o), .if_addr_o(if_addr_o),
    .if_accept_i(if_accept_i), .if_retry_i(if_retry_i), .if_resp_i(if_resp_i),
    .is_mem_i(is_mem_i), .is_prefetch_i(is_prefetch_i), .acc_fault_i(acc_fault_i),
    .dm_req_o(dm_req_o), .dm_accept_i(dm_accept_i), .dm_retry_i(dm_retry_i),
    .dm_resp_i(dm_resp_i), .inst_done_o(inst_done_o), .pc_o(pc_o),
    .state_o(state_o), .cycles_o(cycles_o), .error_o(error_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // fetch at exp_pc, optionally rejected once then retried
  task automatic fetch_phase(input bit reject);
    if (reject) begin
      if_accept_i = 1'b0; #1;
      chk("R3 fetch offered", {31'd0, if_req_o}, 1);
      chk("R3 fetch addr", if_addr_o, exp_pc);
      step();
      chk("R3 enter retry", {29'd0, state_o}, 2);
      #1;
      chk("R3 no resend without retry", {31'd0, if_req_o}, 0);
      step();
      chk("R3 still retry", {29'd0, state_o}, 2);
      chk("R3 addr held", if_addr_o, exp_pc);
      if_retry_i = 1'b1; if_accept_i = 1'b1; #1;
      chk("R3 resend on retry", {31'd0, if_req_o}, 1);
      step();
      if_retry_i = 1'b0;
    end else begin
      if_accept_i = 1'b1; #1;
      chk("R3 fetch offered", {31'd0, if_req_o}, 1);
      chk("R3 fetch addr", if_addr_o, exp_pc);
      step();
    end
    if_accept_i = 1'b0;
    chk("R3 wait after accept", {29'd0, state_o}, 3);
  endtask

  // kind: 0 plain, 1 prefetch, 2 mem ok, 3 mem rejected, 4 access fault
  task automatic resp_phase(input int kind);
    if_resp_i     = 1'b1;
    is_mem_i      = (kind != 0);
    is_prefetch_i = (kind == 1);
    acc_fault_i   = (kind == 4);
    dm_accept_i   = (kind == 2);
    #1;
    if (kind < 2) begin
      chk("R4 retire on fetch response", {31'd0, inst_done_o}, 1);
      chk("R4 no data request", {31'd0, dm_req_o}, 0);
      step();
      exp_pc = exp_pc + 4;
    end else if (kind == 4) begin
      chk("R6 no data request on fault", {31'd0, dm_req_o}, 0);
      chk("R6 retire on fault", {31'd0, inst_done_o}, 1);
      step();
      exp_pc = 32'h100;
    end else begin
      chk("R5 data request with response", {31'd0, dm_req_o}, 1);
      step();
      if_resp_i = 1'b0; is_mem_i = 1'b0;
      if (kind == 3) begin
        chk("R5 data retry state", {29'd0, state_o}, 4);
        #1;
        chk("R5 no data resend", {31'd0, dm_req_o}, 0);
        step();
        dm_retry_i = 1'b1; dm_accept_i = 1'b1; #1;
        chk("R5 data resend on retry", {31'd0, dm_req_o}, 1);
        step();
        dm_retry_i = 1'b0;
      end
      dm_accept_i = 1'b0;
      chk("R5 data wait state", {29'd0, state_o}, 5);
      dm_resp_i = 1'b1; #1;
      chk("R5 retire on data response", {31'd0, inst_done_o}, 1);
      step();
      dm_resp_i = 1'b0;
      exp_pc = exp_pc + 4;
    end
    if_resp_i = 1'b0; is_mem_i = 1'b0; is_prefetch_i = 1'b0;
    acc_fault_i = 1'b0; dm_accept_i = 1'b0;
    chk("R4 back to running", {29'd0, state_o}, 1);
    chk("R4 pc after instruction", pc_o, exp_pc);
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; finished = 0;
    rst_n = 1'b0;
    activate_i = 0; act_delay_i = 0; suspend_i = 0; switch_out_i = 0;
    drain_req_i = 0; intr_i = 0; fetch_fault_i = 0;
    if_accept_i = 0; if_retry_i = 0; if_resp_i = 0;
    is_mem_i = 0; is_prefetch_i = 0; acc_fault_i = 0;
    dm_accept_i = 0; dm_retry_i = 0; dm_resp_i = 0;
    exp_pc = 0;
    #23;
    chk("R1 reset state", {29'd0, state_o}, 0);
    chk("R1 reset pc", pc_o, 0);
    chk("R1 reset request", {31'd0, if_req_o}, 0);
    chk("R1 reset cycles", cycles_o, 0);
    chk("R1 reset error", {31'd0, error_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    c0 = cycles_o;
    for (int k = 0; k < 5; k++) step();
    chk("R12 cycles count in idle", cycles_o, c0 + 5);

    // start-delay sweep
    for (int d = 0; d < 5; d++) begin
      activate_i = 1'b1; act_delay_i = 8'(d);
      step();
      activate_i = 1'b0;
      chk("R2 running after activate", {29'd0, state_o}, 1);
      for (int k = 0; k < d; k++) begin
        #1;
        chk("R2 no fetch during delay", {31'd0, if_req_o}, 0);
        step();
      end
      #1;
      chk("R2 fetch after delay", {31'd0, if_req_o}, 1);
      suspend_i = 1'b1; #1;
      chk("R10 suspend blocks fetch", {31'd0, if_req_o}, 0);
      step();
      suspend_i = 1'b0;
      chk("R10 idle after suspend", {29'd0, state_o}, 0);
      #1;
      chk("R10 no fetch in idle", {31'd0, if_req_o}, 0);
    end

    // instruction mix sweep
    activate_i = 1'b1; act_delay_i = 0;
    step();
    activate_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      fetch_phase(bit'((i / 5) % 2));
      resp_phase(i % 5);
    end

    // fetch fault
    fetch_fault_i = 1'b1; #1;
    chk("R7 no fetch on fault", {31'd0, if_req_o}, 0);
    step();
    fetch_fault_i = 1'b0;
    exp_pc = 32'h100;
    chk("R7 pc to fault vector", pc_o, exp_pc);
    chk("R7 still running", {29'd0, state_o}, 1);
    #1;
    chk("R7 next fetch follows", {31'd0, if_req_o}, 1);

    // interrupt
    intr_i = 1'b1; fetch_fault_i = 1'b1; #1;
    chk("R8 no fetch on interrupt", {31'd0, if_req_o}, 0);
    chk("R8 interrupt ack", {31'd0, intr_ack_o}, 1);
    step();
    intr_i = 1'b0; fetch_fault_i = 1'b0;
    exp_pc = 32'h200;
    chk("R8 pc to interrupt vector", pc_o, exp_pc);

    // drain while running
    drain_req_i = 1'b1; #1;
    chk("R9 drained at once", {31'd0, drained_o}, 1);
    chk("R9 no fetch while drained", {31'd0, if_req_o}, 0);
    step();
    chk("R9 pc kept", pc_o, exp_pc);
    drain_req_i = 1'b0;

    // drain while waiting for fetch response
    fetch_phase(1'b0);
    drain_req_i = 1'b1; #1;
    chk("R9 not drained while busy", {31'd0, drained_o}, 0);
    step();
    if_resp_i = 1'b1; #1;
    chk("R9 no retire when draining", {31'd0, inst_done_o}, 0);
    step();
    if_resp_i = 1'b0;
    chk("R9 running after drain", {29'd0, state_o}, 1);
    chk("R9 pc not advanced", pc_o, exp_pc);
    #1;
    chk("R9 drained after response", {31'd0, drained_o}, 1);
    drain_req_i = 1'b0; if_accept_i = 1'b1; #1;
    chk("R9 refetch same pc", if_addr_o, exp_pc);
    chk("R9 fetch resumes", {31'd0, if_req_o}, 1);

    // suspend while busy
    fetch_phase(1'b0);
    suspend_i = 1'b1;
    step();
    suspend_i = 1'b0;
    if_resp_i = 1'b1; #1;
    chk("R10 instruction finishes", {31'd0, inst_done_o}, 1);
    step();
    if_resp_i = 1'b0;
    exp_pc = exp_pc + 4;
    chk("R10 idle after finish", {29'd0, state_o}, 0);
    chk("R10 pc advanced", pc_o, exp_pc);
    step();
    chk("R10 no fetch in idle", {31'd0, if_req_o}, 0);

    // switched out
    switch_out_i = 1'b1;
    step();
    switch_out_i = 1'b0;
    chk("R11 switched out", {29'd0, state_o}, 6);
    c0 = cycles_o;
    for (int k = 0; k < 3; k++) step();
    chk("R12 cycles hold when switched out", cycles_o, c0);
    activate_i = 1'b1; act_delay_i = 0;
    step();
    activate_i = 1'b0;
    chk("R11 activate leaves switched out", {29'd0, state_o}, 1);

    // protocol error
    chk("R13 no error yet", {31'd0, error_o}, 0);
    dm_resp_i = 1'b1;
    step();
    dm_resp_i = 1'b0;
    chk("R13 error on stray response", {31'd0, error_o}, 1);
    step();
    chk("R13 error sticky", {31'd0, error_o}, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule